// File: doc/BRIEF.md
# Byte-or-Word Parallel Quad Loader

This block is the register file that sits between a parallel processor bus and a four-channel converter. The host selects a channel with a three-bit channel address. It then writes the channel code either as one complete 14-bit word or as two narrower writes. The split path takes the lower eight bits of the code from bus lines 7..0 and the upper six bits from bus lines 5..0. A high/low select input chooses which half each split write updates.

Each channel has two registers. The first is an input register that the bus writes into. The second is a channel latch that drives the converter. A load strobe copies all four input registers into their latches together. If the strobe is held active, each latch follows its input register, so new data is applied as it arrives. An asynchronous clear forces every latch to the mid-scale code 14'h2000 and leaves the input registers alone.

A small strobe state machine qualifies writes. It has two states:
- `ST_IDLE`: the default state. It moves to `ST_ARMED` on the edge where chip-select and write are both sampled low.
- `ST_ARMED`: a write is in progress. If chip-select is sampled high, it returns to `ST_IDLE` and nothing is written (abort). If write is sampled high while chip-select is still low, it returns to `ST_IDLE` and commits the bus data into the addressed input register on that same edge (commit).

Top module: `quad_loader`

## Requirements
- R1: After reset, every channel output and every input register holds 14'h2000.
- R2: With `word_mode`=1, a committed write loads `bus_data[13:0]` into the input register selected by `ch_addr`.
- R3: With `word_mode`=0 and `hi_sel`=0, a committed write loads `bus_data[7:0]` into bits 7..0 of the selected input register and leaves bits 13..8 unchanged.
- R4: With `word_mode`=0 and `hi_sel`=1, a committed write loads `bus_data[5:0]` into bits 13..8 of the selected input register and leaves bits 7..0 unchanged.
- R5: A write commits only on the clock edge where `wr_n` is first sampled high after being sampled low together with `cs_n` low, with `cs_n` still low. If `cs_n` rises first, the input registers are unchanged.
- R6: Writes with `ch_addr` values 4 to 7 change no input register.
- R7: Channel outputs hold their value while `load_n` is high. On each edge where `load_n` is sampled low, all four latches take their input register values.
- R8: While `load_n` stays low, a committed write reaches its channel output on the clock edge after the commit.
- R9: When `clr_n` goes low, every channel output becomes 14'h2000 without waiting for a clock edge. The input registers are unchanged.
- R10: While `clr_n` is low, the outputs stay at 14'h2000 even if `load_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for sampling the bus and the strobes |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Write strobe, active low; commits on its rising edge |
| ch_addr | input | 3 | Channel address; values 0 to 3 select a channel |
| word_mode | input | 1 | 1 selects 14-bit writes, 0 selects split byte writes |
| hi_sel | input | 1 | In split mode, 1 writes the upper 6 bits and 0 writes the lower 8 bits |
| bus_data | input | 14 | Data bus |
| load_n | input | 1 | Load strobe, active low; copies input registers to latches |
| clr_n | input | 1 | Asynchronous clear of the channel latches, active low |
| ch_out | output | 56 | Four channel codes; channel k is on bits 14k+13 down to 14k |

## Verification
The hardest state to reach from the ports is an input register that differs from its latch in only one half. The outputs show the input registers only after a load, so the bench makes random sequences of low-half and high-half split writes to the same channel and sometimes aborts or misaddresses them. It then pulses the load strobe and compares all four channels against a model. Clear pulses are mixed into the random sequence and followed by a load. This shows that the input registers kept their contents through the clear.

// File: rtl/qld_pkg.sv
package qld_pkg;
    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_ARMED = 1'b1
    } strobe_state_t;

    localparam int CODE_W   = 14;
    localparam int LO_W     = 8;
    localparam int HI_W     = CODE_W - LO_W;
    localparam logic [CODE_W-1:0] MID_CODE = 14'h2000;
endpackage

// File: rtl/qld_strobe_fsm.sv
module qld_strobe_fsm
    import qld_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic wr_n,
    output logic commit
);
    strobe_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        commit  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (!cs_n && !wr_n) state_d = ST_ARMED;
            end
            ST_ARMED: begin
                if (cs_n) begin
                    state_d = ST_IDLE;
                end else if (wr_n) begin
                    state_d = ST_IDLE;
                    commit  = 1'b1;
                end
            end
        endcase
    end
endmodule

// File: rtl/qld_input_bank.sv
module qld_input_bank
    import qld_pkg::*;
#(
    parameter int N_CH = 4,
    parameter int AW   = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   commit,
    input  logic [AW-1:0]          ch_addr,
    input  logic                   word_mode,
    input  logic                   hi_sel,
    input  logic [CODE_W-1:0]      bus_data,
    output logic [N_CH*CODE_W-1:0] in_regs
);
    for (genvar i = 0; i < N_CH; i++) begin : g_ch
        logic [CODE_W-1:0] reg_q;
        logic              hit;
        assign hit = commit && (ch_addr == AW'(i));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                reg_q <= MID_CODE;
            end else if (hit) begin
                if (word_mode)   reg_q                <= bus_data;
                else if (hi_sel) reg_q[CODE_W-1:LO_W] <= bus_data[HI_W-1:0];
                else             reg_q[LO_W-1:0]      <= bus_data[LO_W-1:0];
            end
        end
        assign in_regs[i*CODE_W +: CODE_W] = reg_q;
    end
endmodule

// File: rtl/qld_out_latch.sv
module qld_out_latch
    import qld_pkg::*;
#(
    parameter int N_CH = 4
) (
    input  logic                   clk,
    input  logic                   arst_n,
    input  logic                   load_n,
    input  logic [N_CH*CODE_W-1:0] in_regs,
    output logic [N_CH*CODE_W-1:0] ch_out
);
    for (genvar i = 0; i < N_CH; i++) begin : g_lat
        logic [CODE_W-1:0] lat_q;
        always_ff @(posedge clk or negedge arst_n) begin
            if (!arst_n)      lat_q <= MID_CODE;
            else if (!load_n) lat_q <= in_regs[i*CODE_W +: CODE_W];
        end
        assign ch_out[i*CODE_W +: CODE_W] = lat_q;
    end
endmodule

// File: rtl/quad_loader.sv
module quad_loader
    import qld_pkg::*;
#(
    parameter int N_CH = 4,
    parameter int AW   = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cs_n,
    input  logic                   wr_n,
    input  logic [AW-1:0]          ch_addr,
    input  logic                   word_mode,
    input  logic                   hi_sel,
    input  logic [CODE_W-1:0]      bus_data,
    input  logic                   load_n,
    input  logic                   clr_n,
    output logic [N_CH*CODE_W-1:0] ch_out
);
    logic                   wr_commit;
    logic [N_CH*CODE_W-1:0] in_regs;
    logic                   lat_arst_n;

    assign lat_arst_n = rst_n & clr_n;

    qld_strobe_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .cs_n   (cs_n),
        .wr_n   (wr_n),
        .commit (wr_commit)
    );

    qld_input_bank #(.N_CH(N_CH), .AW(AW)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .commit    (wr_commit),
        .ch_addr   (ch_addr),
        .word_mode (word_mode),
        .hi_sel    (hi_sel),
        .bus_data  (bus_data),
        .in_regs   (in_regs)
    );

    qld_out_latch #(.N_CH(N_CH)) u_lat (
        .clk     (clk),
        .arst_n  (lat_arst_n),
        .load_n  (load_n),
        .in_regs (in_regs),
        .ch_out  (ch_out)
    );
endmodule

// File: rtl/qld_checker.sv
module qld_checker
    import qld_pkg::*;
#(
    parameter int N_CH = 4,
    parameter int AW   = 3
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   cs_n,
    input logic                   wr_n,
    input logic [AW-1:0]          ch_addr,
    input logic                   load_n,
    input logic                   clr_n,
    input logic                   wr_commit,
    input logic [N_CH*CODE_W-1:0] in_regs,
    input logic [N_CH*CODE_W-1:0] ch_out
);
    localparam logic [N_CH*CODE_W-1:0] ALL_MID = {N_CH{MID_CODE}};

    AST_CLR_FORCES_MID: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_n |-> ch_out == ALL_MID); // R10

    AST_HOLD_WITHOUT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && clr_n) |=> ($stable(ch_out) || ch_out == ALL_MID)); // R7

    AST_LOAD_COPIES: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_n && clr_n) |=> (!clr_n || ch_out == $past(in_regs))); // R7

    AST_COMMIT_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_commit |-> (!cs_n && wr_n)); // R5

    AST_NO_COMMIT_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_commit |=> $stable(in_regs)); // R5

    AST_HIGH_ADDR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(ch_addr) >= N_CH) |=> $stable(in_regs)); // R6
endmodule

bind quad_loader qld_checker #(.N_CH(N_CH), .AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .wr_n      (wr_n),
    .ch_addr   (ch_addr),
    .load_n    (load_n),
    .clr_n     (clr_n),
    .wr_commit (wr_commit),
    .in_regs   (in_regs),
    .ch_out    (ch_out)
);

// File: tb/quad_loader_tb_top.sv
module quad_loader_tb_top;
    localparam int N = 4;
    localparam int W = 14;
    localparam logic [W-1:0] MID = 14'h2000;

    logic clk = 1'b0;
    logic rst_n, cs_n, wr_n, word_mode, hi_sel, load_n, clr_n;
    logic [2:0]     ch_addr;
    logic [W-1:0]   bus_data;
    logic [N*W-1:0] ch_out;

    logic [W-1:0] exp_in  [N];
    logic [W-1:0] exp_out [N];
    int n_vec = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    quad_loader dut_i (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .ch_addr(ch_addr),
        .word_mode(word_mode), .hi_sel(hi_sel), .bus_data(bus_data),
        .load_n(load_n), .clr_n(clr_n), .ch_out(ch_out)
    );

    function automatic logic [W-1:0] apply_write(logic [W-1:0] old, logic [W-1:0] d,
                                                 logic wm, logic hs);
        if (wm)      return d;
        else if (hs) return {d[5:0], old[7:0]};
        else         return {old[13:8], d[7:0]};
    endfunction

    task automatic check_all(string req);
        for (int c = 0; c < N; c++) begin
            n_vec++;
            if (ch_out[c*W +: W] !== exp_out[c]) begin
                n_bad++;
                $display("FAIL %s ch%0d actual=%h expected=%h", req, c, ch_out[c*W +: W], exp_out[c]);
            end
        end
    endtask

    task automatic do_write(logic [2:0] a, logic [W-1:0] d, logic wm, logic hs, logic abort);
        @(negedge clk);
        cs_n = 1'b0; wr_n = 1'b0; ch_addr = a; bus_data = d; word_mode = wm; hi_sel = hs;
        @(negedge clk);
        wr_n = 1'b1;
        if (abort) cs_n = 1'b1;
        @(negedge clk);
        cs_n = 1'b1;
        if (!abort && a < 3'd4) exp_in[a] = apply_write(exp_in[a], d, wm, hs);
    endtask

    task automatic pulse_load();
        @(negedge clk); load_n = 1'b0;
        @(negedge clk); load_n = 1'b1;
        for (int c = 0; c < N; c++) exp_out[c] = exp_in[c];
    endtask

    task automatic pulse_clear();
        @(negedge clk); clr_n = 1'b0;
        #1;
        for (int c = 0; c < N; c++) exp_out[c] = MID;
        check_all("R9 async clear");
        @(negedge clk); clr_n = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; cs_n = 1'b1; wr_n = 1'b1; ch_addr = '0; word_mode = 1'b1;
        hi_sel = 1'b0; bus_data = '0; load_n = 1'b1; clr_n = 1'b1;
        for (int c = 0; c < N; c++) begin exp_in[c] = MID; exp_out[c] = MID; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1 reset outputs");
        pulse_load(); check_all("R1 reset input regs");

        // R2 word writes, no load yet -> hold (R7)
        do_write(3'd0, 14'h1234, 1'b1, 1'b0, 1'b0);
        do_write(3'd3, 14'h3FFF, 1'b1, 1'b0, 1'b0);
        check_all("R7 hold before load");
        pulse_load(); check_all("R2 word write");
        // R3/R4 split halves
        do_write(3'd1, 14'h3FA5, 1'b0, 1'b0, 1'b0);
        pulse_load(); check_all("R3 low byte");
        do_write(3'd1, 14'h3FFF, 1'b0, 1'b1, 1'b0);
        pulse_load(); check_all("R4 high bits");
        // R5 abort, R6 high address
        do_write(3'd2, 14'h0001, 1'b1, 1'b0, 1'b1);
        do_write(3'd5, 14'h0002, 1'b1, 1'b0, 1'b0);
        do_write(3'd7, 14'h0003, 1'b0, 1'b1, 1'b0);
        pulse_load(); check_all("R5 R6 ignored writes");
        // R8 load held low
        @(negedge clk); load_n = 1'b0;
        do_write(3'd2, 14'h0ABC, 1'b1, 1'b0, 1'b0);
        @(negedge clk);
        for (int c = 0; c < N; c++) exp_out[c] = exp_in[c];
        load_n = 1'b1;
        check_all("R8 follow on new data");
        // R9 / R10
        pulse_clear();
        check_all("R9 after clear release");
        @(negedge clk); clr_n = 1'b0; load_n = 1'b0;
        repeat (2) @(negedge clk);
        check_all("R10 clear over load");
        clr_n = 1'b1; load_n = 1'b1;
        pulse_load(); check_all("R9 input regs kept");

        for (int it = 0; it < 400; it++) begin
            int op;
            op = int'($urandom % 10);
            if (op < 6) begin
                do_write(3'($urandom % 8), 14'($urandom), 1'($urandom), 1'($urandom),
                         ($urandom % 8) == 0);
                check_all("R7 random write hold");
            end else if (op < 8) begin
                pulse_load(); check_all("R2 R3 R4 random load");
            end else if (op == 8) begin
                pulse_clear();
            end else begin
                @(negedge clk); load_n = 1'b0;
                do_write(3'($urandom % 4), 14'($urandom), 1'($urandom), 1'($urandom), 1'b0);
                @(negedge clk);
                for (int c = 0; c < N; c++) exp_out[c] = exp_in[c];
                load_n = 1'b1;
                check_all("R8 random follow");
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule